// File: doc/BRIEF.md
# Terminal Character I/O Interface

This block connects a processor's parallel character port to a serial keyboard and a serial printer. On the keyboard side it accepts one data bit per bit-valid strobe, least significant bit first. It assembles eight bits into a character register and then raises a ready flag. While that flag is up, further keyboard bits are dropped, so an unread character cannot be overwritten. The processor reads the character through a take strobe, which lowers the flag and reopens the keyboard side.

On the printer side, the processor loads a character with a load strobe, but only while the printer-idle flag is high. The load clears that flag. The character then leaves one bit per enable tick, least significant bit first, together with a data-valid strobe. The idle flag rises again once the eighth bit has gone. Both flags are visible to the processor. Their OR forms an interrupt request.

Top module: `term_char_io`

## Requirements
- R1: After reset, inFlag is 0, outFlag is 1, prtBitValid is 0 and irq is 1.
- R2: Each cycle with kbdBitValid high and inFlag low accepts kbdBit. The first accepted bit of a character lands in bit 0 of cpuDataOut and the eighth in bit 7. In the cycle after the eighth accepted bit, inFlag is 1 and cpuDataOut holds the full character.
- R3: While inFlag is 1, keyboard bits are ignored: cpuDataOut and inFlag stay unchanged.
- R4: cpuTake while inFlag is 1 clears inFlag in the next cycle and leaves cpuDataOut unchanged. The next eight accepted bits form a new character.
- R5: cpuLoad while outFlag is 1 captures cpuDataIn and clears outFlag in the next cycle.
- R6: While outFlag is 0, each cycle with prtTick high drives prtBitValid high, with prtBit carrying the next bit of the loaded character, least significant bit first. prtBitValid is 0 in every cycle without prtTick.
- R7: outFlag returns to 1 in the cycle after the eighth prtTick following a load.
- R8: cpuLoad while outFlag is 0 is ignored: the bits still being sent come from the character loaded first.
- R9: cpuTake while inFlag is 0 has no effect. inFlag stays 0 and a partly received character continues from where it was.
- R10: irq equals inFlag OR outFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| kbdBit | input | 1 | Serial keyboard data bit |
| kbdBitValid | input | 1 | Keyboard bit strobe, one bit per high cycle |
| cpuTake | input | 1 | Processor strobe: take the received character |
| cpuLoad | input | 1 | Processor strobe: load a character to print |
| cpuDataIn | input | 8 | Character to print |
| cpuDataOut | output | 8 | Received character register |
| inFlag | output | 1 | Received character ready |
| outFlag | output | 1 | Printer idle, ready for a new character |
| prtTick | input | 1 | Printer enable tick, one bit per high cycle |
| prtBit | output | 1 | Serial printer data bit |
| prtBitValid | output | 1 | Printer data-valid strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. A held character never changes. A take clears a raised input flag. A load clears a raised idle flag. The idle flag cannot rise without a tick. The received-bit counter is also checked to be back at zero whenever a character is waiting. Bit order on both serial sides, the cycle in which each flag rises, and the survival of a partial character across a premature take are shown only by the bench's scenarios. The same holds for a rejected load leaving the printed bits intact: these need the characters the bench chose.

// File: rtl/termio_pkg.sv
package termio_pkg;
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
  } ioStrobes_t;
endpackage

// File: rtl/termio_ctrl.sv
module termio_ctrl
  import termio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kbdBitValid,
  input  logic       cpuTake,
  input  logic       cpuLoad,
  input  logic       prtTick,
  output ioStrobes_t strobes,
  output logic       inFlag,
  output logic       outFlag
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] txCnt;
  logic rxLast;
  logic txLast;

  always_comb begin
    strobes.rxShift = kbdBitValid && !inFlag;
    strobes.txLoad  = cpuLoad && outFlag;
    strobes.txShift = prtTick && !outFlag;
    rxLast = (rxCnt == LAST_IDX);
    txLast = (txCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt  <= '0;
      inFlag <= 1'b0;
    end else if (strobes.rxShift) begin
      if (rxLast) begin
        rxCnt  <= '0;
        inFlag <= 1'b1;
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end else if (cpuTake && inFlag) begin
      inFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt   <= '0;
      outFlag <= 1'b1;
    end else if (strobes.txLoad) begin
      txCnt   <= '0;
      outFlag <= 1'b0;
    end else if (strobes.txShift) begin
      if (txLast) begin
        txCnt   <= '0;
        outFlag <= 1'b1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (cpuTake && inFlag) |=> !inFlag) else $error("take did not clear inFlag"); // R4
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (cpuLoad && outFlag) |=> !outFlag) else $error("load did not clear outFlag"); // R5
  AST_IDLE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN) (!outFlag && !prtTick) |=> !outFlag) else $error("outFlag rose without a tick"); // R7
  AST_RX_CNT_REST: assert property (@(posedge clk) disable iff (!rstN) inFlag |-> (rxCnt == '0)) else $error("bit counter not idle while full"); // R2
endmodule

// File: rtl/termio_datapath.sv
module termio_datapath
  import termio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strobes,
  input  logic              kbdBit,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] inReg,
  output logic              txBit
);
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg <= '0;
    end else if (strobes.rxShift) begin
      inReg <= {kbdBit, inReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobes.txLoad) begin
      outReg <= cpuDataIn;
    end else if (strobes.txShift) begin
      outReg <= {1'b0, outReg[DATA_W-1:1]};
    end
  end

  assign txBit = outReg[0];
endmodule

// File: rtl/term_char_io.sv
module term_char_io
  import termio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdBit,
  input  logic              kbdBitValid,
  input  logic              cpuTake,
  input  logic              cpuLoad,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] cpuDataOut,
  output logic              inFlag,
  output logic              outFlag,
  input  logic              prtTick,
  output logic              prtBit,
  output logic              prtBitValid,
  output logic              irq
);
  ioStrobes_t strobes;

  termio_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .kbdBitValid(kbdBitValid), .cpuTake(cpuTake),
    .cpuLoad(cpuLoad), .prtTick(prtTick), .strobes(strobes),
    .inFlag(inFlag), .outFlag(outFlag)
  );

  termio_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .kbdBit(kbdBit),
    .cpuDataIn(cpuDataIn), .inReg(cpuDataOut), .txBit(prtBit)
  );

  assign prtBitValid = strobes.txShift;
  assign irq         = inFlag | outFlag;

  AST_HOLD_CHAR: assert property (@(posedge clk) disable iff (!rstN) inFlag |=> $stable(cpuDataOut)) else $error("held character changed"); // R3
endmodule

// File: tb/sim_term_char_io.sv
module sim_term_char_io;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbdBit = 1'b0, kbdBitValid = 1'b0, cpuTake = 1'b0, cpuLoad = 1'b0, prtTick = 1'b0;
  logic [7:0] cpuDataIn = 8'h00;
  logic [7:0] cpuDataOut;
  logic inFlag, outFlag, prtBit, prtBitValid, irq;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  term_char_io u0 (
    .clk(clk), .rstN(rstN), .kbdBit(kbdBit), .kbdBitValid(kbdBitValid),
    .cpuTake(cpuTake), .cpuLoad(cpuLoad), .cpuDataIn(cpuDataIn),
    .cpuDataOut(cpuDataOut), .inFlag(inFlag), .outFlag(outFlag),
    .prtTick(prtTick), .prtBit(prtBit), .prtBitValid(prtBitValid), .irq(irq)
  );

  function automatic logic [31:0] expIrq(input logic fIn, input logic fOut);
    return {31'd0, fIn | fOut};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Sends one character LSB first; optionally a premature take after bit 3.
  task automatic sendKey(input logic [7:0] c, input bit midTake);
    for (int i = 0; i < 8; i++) begin
      idle($urandom_range(0, 2));
      if (midTake && i == 4) begin
        cpuTake = 1'b1;
        @(negedge clk);
        cpuTake = 1'b0;
        #1 check("R9 inFlag after early take", {31'd0, inFlag}, 32'd0);
      end
      kbdBit = c[i];
      kbdBitValid = 1'b1;
      @(negedge clk);
      kbdBitValid = 1'b0;
      if (i < 7) begin
        #1 check("R2 inFlag before last bit", {31'd0, inFlag}, 32'd0);
      end
    end
    #1;
    check("R2 inFlag after eighth bit", {31'd0, inFlag}, 32'd1);
    check("R2 character value", {24'd0, cpuDataOut}, {24'd0, c});
  endtask

  task automatic printChar(input logic [7:0] c, input bit tryOverwrite);
    cpuDataIn = c;
    cpuLoad = 1'b1;
    @(negedge clk);
    cpuLoad = 1'b0;
    #1 check("R5 outFlag cleared by load", {31'd0, outFlag}, 32'd0);
    check("R10 irq while busy", {31'd0, irq}, expIrq(inFlag, 1'b0));
    for (int i = 0; i < 8; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      if (tryOverwrite && i == 2) gap = 1;
      for (int g = 0; g < gap; g++) begin
        if (tryOverwrite && i == 2) begin
          cpuDataIn = ~c;
          cpuLoad = 1'b1;
        end
        #1 check("R6 no valid without tick", {31'd0, prtBitValid}, 32'd0);
        @(negedge clk);
        cpuLoad = 1'b0;
      end
      prtTick = 1'b1;
      #1;
      check("R6 valid on tick", {31'd0, prtBitValid}, 32'd1);
      check(tryOverwrite ? "R8 bit after ignored load" : "R6 bit order", {31'd0, prtBit}, {31'd0, c[i]});
      @(negedge clk);
      prtTick = 1'b0;
      #1;
      if (i < 7) check("R7 outFlag low mid-character", {31'd0, outFlag}, 32'd0);
      else check("R7 outFlag high after eighth tick", {31'd0, outFlag}, 32'd1);
    end
  endtask

  initial begin
    logic [7:0] ch;
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    #1;
    check("R1 inFlag reset", {31'd0, inFlag}, 32'd0);
    check("R1 outFlag reset", {31'd0, outFlag}, 32'd1);
    check("R1 prtBitValid reset", {31'd0, prtBitValid}, 32'd0);
    check("R1 R10 irq reset", {31'd0, irq}, 32'd1);

    // Premature take with no character waiting.
    @(negedge clk);
    cpuTake = 1'b1;
    @(negedge clk);
    cpuTake = 1'b0;
    #1 check("R9 take while empty", {31'd0, inFlag}, 32'd0);

    for (int n = 0; n < 8; n++) begin
      ch = (n == 0) ? 8'h01 : (n == 1) ? 8'h80 : 8'($urandom);
      sendKey(ch, n == 2);
      for (int j = 0; j < 3; j++) begin
        kbdBit = ~ch[j];
        kbdBitValid = 1'b1;
        @(negedge clk);
      end
      kbdBitValid = 1'b0;
      #1;
      check("R3 character held", {24'd0, cpuDataOut}, {24'd0, ch});
      check("R3 flag held", {31'd0, inFlag}, 32'd1);
      cpuTake = 1'b1;
      @(negedge clk);
      cpuTake = 1'b0;
      #1;
      check("R4 take clears flag", {31'd0, inFlag}, 32'd0);
      check("R4 character kept", {24'd0, cpuDataOut}, {24'd0, ch});
      check("R10 irq idle printer", {31'd0, irq}, 32'd1);
    end

    for (int n = 0; n < 8; n++) begin
      ch = (n == 0) ? 8'hA5 : 8'($urandom);
      printChar(ch, n == 1 || n == 4);
      idle($urandom_range(0, 2));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule